// File: doc/BRIEF.md
# Half-Duplex SPI Opcode Sequencer

This block is an SPI master whose transfers are described by a small program rather than by per-byte host commands. The host loads a 64-bit program word holding eight byte-wide opcodes. The engine runs them from the top byte downward. Each opcode can drive one of the active-low chip selects, shift up to eight bytes out of a 64-bit transmit holding register, shift up to eight bytes into a 64-bit receive holding register, or end the program.

The host reaches the engine through a register port: one write strobe, one read strobe, a 4-bit register index and 64-bit data. Read data is registered and appears the cycle after the read strobe. Transmit and receive traffic is paced by full flags in a status word, with sticky overrun and underrun flags beside them. The serial side works in SPI mode 0 only, MSB first. The clock rate is set by a divider field.

Top module: `spi_seq_engine`

## Requirements
- R1: After reset the status word (index 0x8) reads 0x0001_0000_0000_0000, so the state field in bits 55:48 is 0x01 (idle) and every flag is clear; all chip selects are high and SCK is low.
- R2: Writing the program (index 0x7) while idle starts execution with the opcode in bits 63:56, then bits 55:48, and so on, returning to idle after a stop (0x00) or after the eighth slot. Opcode 0x1n with n in 1..4 drives only chip select n-1 low; 0x10 (or n above 4) drives all chip selects high.
- R3: Opcode 0x3n (n in 1..8) sends n bytes taken from the transmit register (index 0x5) starting at bits 63:56, MSB first.
- R4: SCK idles low and its period is 2×(D+1) system clocks, where D is bits 63:52 of the clock register (index 0x3), which read back in the same place. The line is sampled on the rising edge and changed on the falling edge, one edge pair per bit.
- R5: Opcode 0x4n (n in 1..8) receives n bytes into the receive register (index 0x6), right-aligned with the last byte in bits 7:0, and sets status bit 63; reading index 0x6 clears bit 63.
- R6: A transmit write sets status bit 59. The engine clears bit 59 once the shift-out opcode that used the data has finished. A transmit write made while bit 59 is set is dropped and sets status bit 58.
- R7: A shift-out opcode that finds bit 59 clear waits with chip selects held and SCK still. A stop or deselect reached while bit 59 is set sets status bit 57.
- R8: Receive data arriving while bit 63 is set sets status bit 62; reading index 0x6 while bit 63 is clear sets status bit 61.
- R9: A shift-in opcode that is not preceded by a shift-out in the same program is skipped: no SCK edges, no receive data.
- R10: A status write keeps each of bits 63, 62, 61, 59, 58 and 57 only where the written data has a one there; writing zero clears them all.
- R11: Writing the clock register with bits 36 and 38 set, then with bits 37 and 39 set, resets the engine: idle state, all flags clear, chip selects high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_idx | input | 4 | Register index |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, valid the cycle after reg_rd |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| cs_n | output | NUM_CS | Active-low chip selects |

## Verification
A slave model records every bit seen on the rising edge and feeds a known pattern back. A table of programs then sweeps shift-out lengths of one, three, four and eight bytes, with and without a following shift-in, under three divider values. This separates byte ordering and alignment faults from clock-rate and bit-count faults: a wrong byte lane shows up in the captured data, and a wrong divider shows up in the edge count or the measured period. Directed cases then drive the handshake paths one at a time: a stalled shift-out, a stop with unused data, a dropped overrun write, reads of an empty receive register, back-to-back receive results, a shift-in with no prior shift-out, masked status clears and the two-step reset. Each of these flips one distinct flag or leaves a distinct line quiet.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

  localparam int REG_W  = 64;
  localparam int OP_W   = 8;
  localparam int SLOTS  = REG_W / OP_W;

  // host register indices
  localparam logic [3:0] IDX_CLK  = 4'h3;
  localparam logic [3:0] IDX_TXD  = 4'h5;
  localparam logic [3:0] IDX_RXD  = 4'h6;
  localparam logic [3:0] IDX_PROG = 4'h7;
  localparam logic [3:0] IDX_STAT = 4'h8;

  // status bit positions
  localparam int ST_RX_FULL = 63;
  localparam int ST_RX_OVR  = 62;
  localparam int ST_RX_UND  = 61;
  localparam int ST_TX_FULL = 59;
  localparam int ST_TX_OVR  = 58;
  localparam int ST_TX_UND  = 57;

  // two-step engine reset bits in the clock register
  localparam int RST_A0 = 36;
  localparam int RST_A1 = 38;
  localparam int RST_B0 = 37;
  localparam int RST_B1 = 39;

  // opcode classes (upper nibble)
  localparam logic [3:0] OPC_STOP = 4'h0;
  localparam logic [3:0] OPC_SEL  = 4'h1;
  localparam logic [3:0] OPC_OUT  = 4'h3;
  localparam logic [3:0] OPC_IN   = 4'h4;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_FETCH,
    SQ_WAIT_TX,
    SQ_SHIFT
  } sq_state_t;

  function automatic logic [7:0] state_code(input sq_state_t s);
    case (s)
      SQ_IDLE:    return 8'h01;
      SQ_FETCH:   return 8'h02;
      SQ_WAIT_TX: return 8'h04;
      default:    return 8'h08;
    endcase
  endfunction

endpackage

// File: rtl/spi_seq_tick.sv
module spi_seq_tick #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == div) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

endmodule

// File: rtl/spi_seq_shift.sv
module spi_seq_shift #(
  parameter int DW    = 64,
  parameter int DIV_W = 12,
  localparam int CW   = $clog2(DW + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CW-1:0]    nbits,
  input  logic [DW-1:0]    txd,
  input  logic [DIV_W-1:0] div,
  input  logic             miso,
  output logic             sck,
  output logic             mosi,
  output logic             busy,
  output logic             done,
  output logic [DW-1:0]    rxd
);

  logic          tick;
  logic [DW-1:0] sr;
  logic [CW-1:0] left;

  spi_seq_tick #(.DIV_W(DIV_W)) tick_i (
    .clk  (clk),
    .rst  (rst),
    .en   (busy),
    .div  (div),
    .tick (tick)
  );

  assign mosi = sr[DW-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sr   <= '0;
      left <= '0;
      busy <= 1'b0;
      done <= 1'b0;
      sck  <= 1'b0;
      rxd  <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        sr   <= txd;
        left <= nbits;
        rxd  <= '0;
        busy <= 1'b1;
        sck  <= 1'b0;
      end else if (busy && tick) begin
        if (!sck) begin
          sck <= 1'b1;
          rxd <= {rxd[DW-2:0], miso};
        end else begin
          sck  <= 1'b0;
          sr   <= sr << 1;
          left <= left - 1'b1;
          if (left == CW'(1)) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end
      end
    end
  end

  // R4
  sck_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sck);

  // R4
  sck_pace_chk: assert property (@(posedge clk) disable iff (rst)
    (sck != $past(sck)) |-> $past(tick));

endmodule

// File: rtl/spi_seq_ctrl.sv
module spi_seq_ctrl
  import spi_seq_pkg::*;
#(
  parameter int NUM_CS = 4,
  localparam int SW    = $clog2(SLOTS + 1),
  localparam int CW    = $clog2(REG_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [REG_W-1:0]  prog,
  input  logic              tx_full,
  input  logic              sh_done,
  output logic              sh_start,
  output logic [CW-1:0]     sh_nbits,
  output logic              sh_use_tx,
  output logic              tx_taken,
  output logic              rx_taken,
  output logic              tx_under,
  output logic [NUM_CS-1:0] cs_n,
  output logic [7:0]        st_code
);

  localparam logic [3:0] NCS4 = 4'(NUM_CS);

  sq_state_t         st;
  logic [REG_W-1:0]  prog_sr;
  logic [SW-1:0]     slot;
  logic              seen_out;

  logic [3:0]    op_cls, op_arg, op_len;
  logic          tx_avail;

  assign op_cls   = prog_sr[REG_W-1 -: 4];
  assign op_arg   = prog_sr[REG_W-5 -: 4];
  assign op_len   = (op_arg > 4'd8) ? 4'd8 : op_arg;
  assign tx_avail = tx_full && !tx_taken;
  assign st_code  = state_code(st);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= SQ_IDLE;
      prog_sr   <= '0;
      slot      <= '0;
      seen_out  <= 1'b0;
      sh_start  <= 1'b0;
      sh_nbits  <= '0;
      sh_use_tx <= 1'b0;
      tx_taken  <= 1'b0;
      rx_taken  <= 1'b0;
      tx_under  <= 1'b0;
      cs_n      <= '1;
    end else begin
      sh_start <= 1'b0;
      tx_taken <= 1'b0;
      rx_taken <= 1'b0;
      tx_under <= 1'b0;
      case (st)
        SQ_IDLE: begin
          if (go) begin
            prog_sr  <= prog;
            slot     <= '0;
            seen_out <= 1'b0;
            st       <= SQ_FETCH;
          end
        end
        SQ_FETCH: begin
          if (slot == SW'(SLOTS)) begin
            st <= SQ_IDLE;
          end else begin
            st      <= SQ_FETCH;
            prog_sr <= prog_sr << OP_W;
            slot    <= slot + 1'b1;
            case (op_cls)
              OPC_STOP: begin
                tx_under <= tx_avail;
                st       <= SQ_IDLE;
              end
              OPC_SEL: begin
                if (op_arg != 4'd0 && op_arg <= NCS4) begin
                  cs_n <= ~(NUM_CS'(1) << (op_arg - 4'd1));
                end else begin
                  cs_n     <= '1;
                  tx_under <= tx_avail;
                end
              end
              OPC_OUT: begin
                if (op_len != 4'd0) begin
                  seen_out  <= 1'b1;
                  sh_nbits  <= {op_len, 3'b000};
                  sh_use_tx <= 1'b1;
                  prog_sr   <= prog_sr;
                  slot      <= slot;
                  st        <= SQ_WAIT_TX;
                end
              end
              OPC_IN: begin
                if (op_len != 4'd0 && seen_out) begin
                  sh_nbits  <= {op_len, 3'b000};
                  sh_use_tx <= 1'b0;
                  sh_start  <= 1'b1;
                  prog_sr   <= prog_sr;
                  slot      <= slot;
                  st        <= SQ_SHIFT;
                end
              end
              default: ;
            endcase
          end
        end
        SQ_WAIT_TX: begin
          if (tx_avail) begin
            sh_start <= 1'b1;
            st       <= SQ_SHIFT;
          end
        end
        default: begin
          if (sh_done) begin
            tx_taken <= sh_use_tx;
            rx_taken <= !sh_use_tx;
            prog_sr  <= prog_sr << OP_W;
            slot     <= slot + 1'b1;
            st       <= SQ_FETCH;
          end
        end
      endcase
    end
  end

  // R7
  out_waits_tx_chk: assert property (@(posedge clk) disable iff (rst)
    (sh_start && sh_use_tx) |-> $past(tx_full));

  // R2
  cs_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n));

  // R9
  in_after_out_chk: assert property (@(posedge clk) disable iff (rst)
    (sh_start && !sh_use_tx) |-> seen_out);

endmodule

// File: rtl/spi_seq_engine.sv
module spi_seq_engine
  import spi_seq_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int DIV_W  = 12,
  localparam int CW    = $clog2(REG_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [3:0]        reg_idx,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] cs_n
);

  logic             srst, soft_rst, armed;
  logic [DIV_W-1:0] div;
  logic [REG_W-1:0] tx_data, rx_data, sh_rxd, stat_word;
  logic             tx_full, tx_ovr, tx_und, rx_full, rx_ovr, rx_und;
  logic             sh_start, sh_use_tx, sh_busy, sh_done;
  logic [CW-1:0]    sh_nbits;
  logic             tx_taken, rx_taken, tx_under;
  logic [7:0]       st_code;
  logic             wr_clk, wr_tx, wr_prog, wr_stat, rd_rx;
  logic             pat_a, pat_b;

  assign srst    = rst || soft_rst;
  assign wr_clk  = reg_wr && (reg_idx == IDX_CLK);
  assign wr_tx   = reg_wr && (reg_idx == IDX_TXD);
  assign wr_prog = reg_wr && (reg_idx == IDX_PROG);
  assign wr_stat = reg_wr && (reg_idx == IDX_STAT);
  assign rd_rx   = reg_rd && (reg_idx == IDX_RXD);
  assign pat_a   = reg_wdata[RST_A0] && reg_wdata[RST_A1] && !reg_wdata[RST_B0] && !reg_wdata[RST_B1];
  assign pat_b   = reg_wdata[RST_B0] && reg_wdata[RST_B1] && !reg_wdata[RST_A0] && !reg_wdata[RST_A1];

  assign stat_word = {rx_full, rx_ovr, rx_und, 1'b0, tx_full, tx_ovr, tx_und, 1'b0,
                      st_code, {(REG_W-16){1'b0}}};

  spi_seq_ctrl #(.NUM_CS(NUM_CS)) ctrl_i (
    .clk       (clk),
    .rst       (srst),
    .go        (wr_prog),
    .prog      (reg_wdata),
    .tx_full   (tx_full),
    .sh_done   (sh_done),
    .sh_start  (sh_start),
    .sh_nbits  (sh_nbits),
    .sh_use_tx (sh_use_tx),
    .tx_taken  (tx_taken),
    .rx_taken  (rx_taken),
    .tx_under  (tx_under),
    .cs_n      (cs_n),
    .st_code   (st_code)
  );

  spi_seq_shift #(.DW(REG_W), .DIV_W(DIV_W)) shift_i (
    .clk   (clk),
    .rst   (srst),
    .start (sh_start),
    .nbits (sh_nbits),
    .txd   (sh_use_tx ? tx_data : '0),
    .div   (div),
    .miso  (miso),
    .sck   (sck),
    .mosi  (mosi),
    .busy  (sh_busy),
    .done  (sh_done),
    .rxd   (sh_rxd)
  );

  // clock register and two-step engine reset
  always_ff @(posedge clk) begin
    if (rst) begin
      div      <= '0;
      armed    <= 1'b0;
      soft_rst <= 1'b0;
    end else begin
      soft_rst <= 1'b0;
      if (wr_clk) begin
        div <= reg_wdata[REG_W-1 -: DIV_W];
        if (pat_a) begin
          armed <= 1'b1;
        end else begin
          armed <= 1'b0;
          if (armed && pat_b) soft_rst <= 1'b1;
        end
      end
    end
  end

  // data holding registers and flags
  always_ff @(posedge clk) begin
    if (srst) begin
      tx_data <= '0;
      rx_data <= '0;
      tx_full <= 1'b0;
      tx_ovr  <= 1'b0;
      tx_und  <= 1'b0;
      rx_full <= 1'b0;
      rx_ovr  <= 1'b0;
      rx_und  <= 1'b0;
    end else begin
      if (wr_tx && !tx_full) begin
        tx_data <= reg_wdata;
        tx_full <= 1'b1;
      end else if (tx_taken) begin
        tx_full <= 1'b0;
      end
      if (wr_tx && tx_full) tx_ovr <= 1'b1;
      if (tx_under) tx_und <= 1'b1;
      if (rx_taken) begin
        rx_data <= sh_rxd;
        rx_full <= 1'b1;
        if (rx_full) rx_ovr <= 1'b1;
      end else if (rd_rx) begin
        if (!rx_full) rx_und <= 1'b1;
        rx_full <= 1'b0;
      end
      if (wr_stat) begin
        rx_full <= rx_full && reg_wdata[ST_RX_FULL];
        rx_ovr  <= rx_ovr  && reg_wdata[ST_RX_OVR];
        rx_und  <= rx_und  && reg_wdata[ST_RX_UND];
        tx_full <= tx_full && reg_wdata[ST_TX_FULL];
        tx_ovr  <= tx_ovr  && reg_wdata[ST_TX_OVR];
        tx_und  <= tx_und  && reg_wdata[ST_TX_UND];
      end
    end
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_idx)
        IDX_CLK:  reg_rdata <= {div, {(REG_W-DIV_W){1'b0}}};
        IDX_TXD:  reg_rdata <= tx_data;
        IDX_RXD:  reg_rdata <= rx_data;
        IDX_STAT: reg_rdata <= stat_word;
        default:  reg_rdata <= '0;
      endcase
    end
  end

  // R6
  tx_drop_chk: assert property (@(posedge clk) disable iff (srst)
    (wr_tx && tx_full) |=> $stable(tx_data));

  // R5
  rx_full_set_chk: assert property (@(posedge clk) disable iff (srst)
    (rx_taken && !wr_stat) |=> rx_full);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (srst)
    (st_code == 8'h01) |-> (!sck && !sh_busy));

endmodule

// File: tb/spi_seq_engine_tb.sv
`timescale 1ns/1ps
module spi_seq_engine_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [3:0]  reg_idx = 4'h0;
  logic [63:0] reg_wdata = 64'h0;
  logic [63:0] reg_rdata;
  logic        sck, mosi, miso;
  logic [3:0]  cs_n;

  always #2.5 clk = ~clk;

  spi_seq_engine dut_i (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_idx   (reg_idx),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .sck       (sck),
    .mosi      (mosi),
    .miso      (miso),
    .cs_n      (cs_n)
  );

  // slave model: captures on rising SCK, presents pattern bits in order
  logic [127:0] slv_pat = '0;
  logic         slv_clr = 1'b0;
  logic [127:0] cap;
  logic [7:0]   nb;

  assign miso = slv_pat[7'd127 - nb[6:0]];

  always @(posedge sck or posedge slv_clr) begin
    if (slv_clr) begin
      cap <= '0;
      nb  <= '0;
    end else begin
      cap <= {cap[126:0], mosi};
      nb  <= nb + 8'd1;
    end
  end

  int checks = 0;
  int errors = 0;

  // tx data, miso pattern, out bytes, in bytes, divider
  localparam logic [147:0] VECS [4] = '{
    {64'hA500_0000_0000_0000, 64'h3C00_0000_0000_0000, 4'd1, 4'd1, 12'd0},
    {64'h1234_5600_0000_0000, 64'hDEAD_BEEF_CAFE_F00D, 4'd3, 4'd2, 12'd2},
    {64'h0123_4567_89AB_CDEF, 64'hF0E1_D2C3_B4A5_9687, 4'd8, 4'd8, 12'd1},
    {64'h8001_FF7E_0000_0000, 64'h0000_0000_0000_0000, 4'd4, 4'd0, 12'd0}
  };

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] idx, input logic [63:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_idx = idx; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] idx, output logic [63:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_idx = idx;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wait_idle(output bit ok);
    logic [63:0] s;
    ok = 1'b0;
    for (int k = 0; k < 4000; k++) begin
      rd(4'h8, s);
      if (s[55:48] == 8'h01) begin
        ok = 1'b1;
        break;
      end
    end
  endtask

  task automatic slave_load(input logic [127:0] p);
    slv_pat = p;
    slv_clr = 1'b1;
    #1 slv_clr = 1'b0;
  endtask

  initial begin
    #900000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] s, d, tx, pat;
    logic [127:0] e, t;
    logic [3:0] n4, m4;
    logic [11:0] dv;
    int nn, mm;
    bit ok;
    realtime t0, t1;

    slave_load('0);
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(4'h8, s);
    chk(s == 64'h0001_0000_0000_0000, "R1 status", s, 64'h0001_0000_0000_0000);
    chk(cs_n == 4'hF && sck == 1'b0, "R1 pins", {cs_n, sck}, {4'hF, 1'b0});

    // table walk: R2 R3 R4 R5 R6
    for (int i = 0; i < 4; i++) begin
      tx = VECS[i][147:84];
      pat = VECS[i][83:20];
      n4 = VECS[i][19:16];
      m4 = VECS[i][15:12];
      dv = VECS[i][11:0];
      nn = int'(n4);
      mm = int'(m4);
      wr(4'h3, {dv, 52'h0});
      slave_load({pat, 64'h0});
      wr(4'h5, tx);
      if (mm != 0) wr(4'h7, {8'h11, 4'h3, n4, 4'h4, m4, 8'h10, 32'h0});
      else         wr(4'h7, {8'h11, 4'h3, n4, 8'h10, 40'h0});
      wait_idle(ok);
      chk(ok, "R2 program reaches idle", {127'h0, ok}, 128'h1);
      e = ({64'h0, tx} >> (64 - 8 * nn)) << (8 * mm);
      chk(cap == e, "R3 bytes out", cap, e);
      chk(nb == 8'(8 * (nn + mm)), "R4 edge count", nb, 8 * (nn + mm));
      chk(cs_n == 4'hF, "R2 deselect at end", cs_n, 4'hF);
      rd(4'h8, s);
      chk(s[59] == 1'b0, "R6 full cleared after shift", s[59], 1'b0);
      if (mm != 0) begin
        chk(s[63] == 1'b1, "R5 rx full set", s[63], 1'b1);
        rd(4'h6, d);
        t = {pat, 64'h0} << (8 * nn);
        e = {64'h0, t[127:64] >> (64 - 8 * mm)};
        chk(d == e[63:0], "R5 rx right aligned", d, e);
        rd(4'h8, s);
        chk(s[63] == 1'b0, "R5 read clears full", s[63], 1'b0);
      end
    end

    // R4 clock period and divider readback
    wr(4'h3, {12'd3, 52'h0});
    rd(4'h3, d);
    chk(d == {12'd3, 52'h0}, "R4 divider readback", d, {12'd3, 52'h0});
    slave_load('0);
    wr(4'h5, 64'hFFFF_0000_0000_0000);
    wr(4'h7, {8'h11, 8'h32, 8'h10, 40'h0});
    @(posedge sck); t0 = $realtime;
    @(posedge sck); t1 = $realtime;
    chk(int'((t1 - t0) / 5.0) == 8, "R4 sck period", int'((t1 - t0) / 5.0), 8);
    wait_idle(ok);

    // R2 select and deselect
    wr(4'h7, {8'h13, 56'h0});
    wait_idle(ok);
    chk(cs_n == 4'b1011, "R2 select 3", cs_n, 4'b1011);
    wr(4'h7, {8'h10, 56'h0});
    wait_idle(ok);
    chk(cs_n == 4'hF, "R2 deselect", cs_n, 4'hF);

    // R7 stall without transmit data
    wr(4'h3, 64'h0);
    slave_load('0);
    wr(4'h7, {8'h12, 8'h31, 8'h10, 40'h0});
    repeat (40) @(negedge clk);
    rd(4'h8, s);
    chk(s[55:48] != 8'h01, "R7 stalled not idle", s[55:48], 8'h04);
    chk(cs_n == 4'b1101, "R7 cs held", cs_n, 4'b1101);
    chk(nb == 8'd0, "R7 no sck while stalled", nb, 0);
    wr(4'h5, 64'h5A00_0000_0000_0000);
    wait_idle(ok);
    chk(cap[7:0] == 8'h5A && nb == 8'd8, "R7 resumes after write", cap[7:0], 8'h5A);

    // R7 underrun: stop with unused transmit data
    wr(4'h5, 64'h7700_0000_0000_0000);
    wr(4'h7, {8'h11, 8'h00, 48'h0});
    wait_idle(ok);
    rd(4'h8, s);
    chk(s[57] == 1'b1, "R7 underrun on stop", s[57], 1'b1);
    chk(s[59] == 1'b1, "R6 full kept", s[59], 1'b1);

    // R6 overrun write dropped
    wr(4'h5, 64'h9900_0000_0000_0000);
    rd(4'h8, s);
    chk(s[58] == 1'b1, "R6 overrun flag", s[58], 1'b1);
    slave_load('0);
    wr(4'h7, {8'h11, 8'h31, 8'h10, 40'h0});
    wait_idle(ok);
    chk(cap[7:0] == 8'h77, "R6 overrun write dropped", cap[7:0], 8'h77);

    // R10 masked clear
    wr(4'h8, 64'h0400_0000_0000_0000);
    rd(4'h8, s);
    chk(s[58] == 1'b1 && s[57] == 1'b0, "R10 masked clear", s[58:57], 2'b10);
    wr(4'h8, 64'h0);
    rd(4'h8, s);
    chk((s & 64'hEE00_0000_0000_0000) == 64'h0, "R10 clear all", s, 64'h0001_0000_0000_0000);

    // R8 receive underrun and overrun
    rd(4'h6, d);
    rd(4'h8, s);
    chk(s[61] == 1'b1, "R8 read of empty rx", s[61], 1'b1);
    for (int k = 0; k < 2; k++) begin
      slave_load('0);
      wr(4'h5, 64'h0100_0000_0000_0000);
      wr(4'h7, {8'h11, 8'h31, 8'h41, 8'h10, 32'h0});
      wait_idle(ok);
    end
    rd(4'h8, s);
    chk(s[62] == 1'b1, "R8 rx overrun", s[62], 1'b1);
    wr(4'h8, 64'h0);

    // R9 shift-in without prior shift-out
    slave_load({64'hFFFF_FFFF_FFFF_FFFF, 64'h0});
    wr(4'h7, {8'h11, 8'h42, 8'h10, 40'h0});
    wait_idle(ok);
    chk(nb == 8'd0, "R9 no clocks", nb, 0);
    rd(4'h8, s);
    chk(s[63] == 1'b0, "R9 no rx data", s[63], 1'b0);

    // R11 two-step engine reset
    wr(4'h7, {8'h12, 8'h31, 48'h0});
    rd(4'h6, d);
    repeat (10) @(negedge clk);
    chk(cs_n == 4'b1101, "R11 precondition cs", cs_n, 4'b1101);
    wr(4'h3, 64'h0000_0050_0000_0000);
    wr(4'h3, 64'h0000_00A0_0000_0000);
    rd(4'h8, s);
    chk(s == 64'h0001_0000_0000_0000, "R11 status after reset", s, 64'h0001_0000_0000_0000);
    chk(cs_n == 4'hF, "R11 cs released", cs_n, 4'hF);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule